// File: doc/BRIEF.md
# Dual-Rail Four-Phase Half Latch

This block is one register stage of a self-timed pipeline that carries dual-rail data. Each bit travels on two wires. A high true wire means one, a high false wire means zero, and both wires low means the bit is empty. The stage talks to its neighbours through a four-phase handshake. Upstream presents a complete word and waits for `up_ack` to rise. It then returns all wires to empty and waits for `up_ack` to fall. Downstream answers in the same way on `dn_ack`.

Every rail is held by a C-element. The first input of the C-element is the incoming rail and the second is the inverse of `dn_ack`. A rail therefore captures only while downstream is idle, and it clears only after downstream has taken the value and the input has gone empty. The two stored rails of a bit are ORed to show that the bit is present. A multi-input C-element joins these per-bit signals across the word, so `up_ack` rises only when every bit is present and falls only when every bit is empty. In this code base each C-element is modelled as a state bit that updates once per clock.

Top module: `dr_half_latch`

## Requirements
- R1: While `rst_n` is low, every bit of `q_t` and `q_f` is 0 and `up_ack` is 0.
- R2: On a clock edge where `dn_ack` is 0, any input rail (`d_t[i]` or `d_f[i]`) that is 1 makes the matching stored rail 1 after that edge.
- R3: On a clock edge where `dn_ack` is 1, any input rail that is 0 makes the matching stored rail 0 after that edge.
- R4: In every other case the stored rail keeps its value. A valid input is not captured while `dn_ack` is 1, and an empty input does not clear the stage while `dn_ack` is 0.
- R5: As long as the input never shows both rails of a bit at 1, the stored `q_t[i]` and `q_f[i]` are never both 1.
- R6: `up_ack` becomes 1 at the edge after which every bit holds a valid rail. It becomes 0 at the edge after which every bit is empty. When only some bits are present it keeps its value.
- R7: Encoding per bit: `t=1,f=0` is logic 1, `t=0,f=1` is logic 0, and `t=0,f=0` is empty. With four-phase neighbours that use random delays, every word reaches the output intact and in the order it was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that updates the modelled C-elements |
| rst_n | input | 1 | Asynchronous reset, active low, sets the stage to empty |
| d_t | input | WIDTH | Incoming true rails |
| d_f | input | WIDTH | Incoming false rails |
| up_ack | output | 1 | Acknowledge returned to the upstream stage |
| q_t | output | WIDTH | Stored true rails |
| q_f | output | WIDTH | Stored false rails |
| dn_ack | input | 1 | Acknowledge from the downstream stage |

## Verification
The directed patterns come first. A valid word is presented while `dn_ack` is high, which shows that capture is gated (R4) and not free-running. The input is then emptied while `dn_ack` is low, which shows that the stage holds its value rather than following the input. A single-bit partial word separates all-bits completion from an any-bit OR on `up_ack`. In the random phase, producer and consumer use independent delays and fill and empty bits one at a time. A behavioural per-rail model is compared on every clock, and a queue confirms word order and values.

// File: rtl/dr_half_latch_pkg.sv
package dr_half_latch_pkg;

    typedef struct packed {
        logic t;
        logic f;
    } dr_pair_t;

    // Next state of a two-input C-element: follow when inputs agree, else hold
    function automatic logic celem2(input logic a, input logic b, input logic q);
        return (a & b) | (q & (a | b));
    endfunction

endpackage

// File: rtl/dr_rail_store.sv
module dr_rail_store
    import dr_half_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_t,
    input  logic in_f,
    input  logic gate,      // inverse of downstream acknowledge
    output logic st_t,
    output logic st_f,
    output logic full_d     // bit present after the coming edge
);

    dr_pair_t pair_d, pair_q;

    always_comb begin
        pair_d   = pair_q;
        pair_d.t = celem2(in_t, gate, pair_q.t);
        pair_d.f = celem2(in_f, gate, pair_q.f);
        full_d   = pair_d.t | pair_d.f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign st_t = pair_q.t;
    assign st_f = pair_q.f;

endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] full_d,
    output logic             done_q
);

    typedef struct packed {
        logic done;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic all_set, none_set;

    always_comb begin
        all_set  = &full_d;
        none_set = ~|full_d;
        st_d     = st_q;
        if (all_set)       st_d.done = 1'b1;
        else if (none_set) st_d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_q = st_q.done;

endmodule

// File: rtl/dr_half_latch.sv
module dr_half_latch #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_t,
    input  logic [WIDTH-1:0] d_f,
    output logic             up_ack,
    output logic [WIDTH-1:0] q_t,
    output logic [WIDTH-1:0] q_f,
    input  logic             dn_ack
);

    localparam int LAST = WIDTH - 1;

    logic             gate_n;
    logic [LAST:0]    full_d;

    assign gate_n = ~dn_ack;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        dr_rail_store u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_t   (d_t[i]),
            .in_f   (d_f[i]),
            .gate   (gate_n),
            .st_t   (q_t[i]),
            .st_f   (q_f[i]),
            .full_d (full_d[i])
        );
    end

    dr_completion #(.WIDTH(WIDTH)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .full_d (full_d),
        .done_q (up_ack)
    );

endmodule

// File: rtl/dr_half_latch_chk.sv
module dr_half_latch_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] d_t,
    input logic [WIDTH-1:0] d_f,
    input logic             up_ack,
    input logic [WIDTH-1:0] q_t,
    input logic [WIDTH-1:0] q_f,
    input logic             dn_ack
);

    always_comb begin
        if (!rst_n) begin
            p_reset_empty_r1: assert ((q_t == '0) && (q_f == '0) && !up_ack);
        end
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_ack |=> (((q_t & $past(d_t)) == $past(d_t)) && ((q_f & $past(d_f)) == $past(d_f))));

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_ack |=> (((q_t & ~$past(d_t)) == '0) && ((q_f & ~$past(d_f)) == '0)));

    p_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_ack |=> (((q_t & ~$past(q_t)) == '0) && ((q_f & ~$past(q_f)) == '0)));

    p_no_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_ack |=> (((~q_t & $past(q_t)) == '0) && ((~q_f & $past(q_f)) == '0)));

    p_rails_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((d_t & d_f) == '0) |=> ((q_t & q_f) == '0));

    p_ack_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&(q_t | q_f)) |-> up_ack);

    p_ack_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (~|(q_t | q_f)) |-> !up_ack);

    p_ack_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_ack) |-> (&(q_t | q_f)));

endmodule

bind dr_half_latch dr_half_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_t    (d_t),
    .d_f    (d_f),
    .up_ack (up_ack),
    .q_t    (q_t),
    .q_f    (q_f),
    .dn_ack (dn_ack)
);

// File: tb/dr_half_latch_tb_top.sv
module dr_half_latch_tb_top;

    localparam int WIDTH   = 4;
    localparam int CLK_PER = 10;
    localparam int NTOK    = 40;
    localparam int WDOG    = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] d_t = '0;
    logic [WIDTH-1:0] d_f = '0;
    logic             dn_ack = 1'b0;
    logic             up_ack;
    logic [WIDTH-1:0] q_t, q_f;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    logic [WIDTH-1:0] m_t = '0, m_f = '0;
    logic             m_ack = 1'b0;
    logic [WIDTH-1:0] sent_q[$];
    int               rx_cnt = 0;

    always #(CLK_PER/2) clk = ~clk;

    dr_half_latch #(.WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .d_t(d_t), .d_f(d_f),
        .up_ack(up_ack), .q_t(q_t), .q_f(q_f), .dn_ack(dn_ack)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: each rail sets while downstream idle, drops once taken and input empty
    always @(posedge clk) begin
        logic [WIDTH-1:0] nt, nf;
        if (!rst_n) begin
            m_t <= '0; m_f <= '0; m_ack <= 1'b0;
        end else begin
            nt = m_t; nf = m_f;
            for (int i = 0; i < WIDTH; i++) begin
                if (!dn_ack && d_t[i]) nt[i] = 1'b1;
                if (dn_ack && !d_t[i]) nt[i] = 1'b0;
                if (!dn_ack && d_f[i]) nf[i] = 1'b1;
                if (dn_ack && !d_f[i]) nf[i] = 1'b0;
            end
            m_t <= nt; m_f <= nf;
            if (&(nt | nf))       m_ack <= 1'b1;
            else if (~|(nt | nf)) m_ack <= 1'b0;
        end
        cycles++;
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check(q_t == m_t, "R2/R3/R4 model q_t", q_t, m_t);
            check(q_f == m_f, "R2/R3/R4 model q_f", q_f, m_f);
            check(up_ack == m_ack, "R6 model up_ack", up_ack, m_ack);
            check((q_t & q_f) == '0, "R5 rails exclusive", q_t & q_f, 0);
        end
    end

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send(input logic [WIDTH-1:0] w);
        while (up_ack) @(negedge clk);
        sent_q.push_back(w);
        for (int i = 0; i < WIDTH; i++) begin
            cyc($urandom_range(0, 3));
            if (w[i]) d_t[i] = 1'b1; else d_f[i] = 1'b1;
        end
        while (!up_ack) @(negedge clk);
        for (int i = 0; i < WIDTH; i++) begin
            cyc($urandom_range(0, 3));
            d_t[i] = 1'b0; d_f[i] = 1'b0;
        end
        while (up_ack) @(negedge clk);
    endtask

    initial begin : watchdog
        while (cycles < WDOG && !done) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", rx_cnt, NTOK);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : consumer
        wait (model_on);
        while (rx_cnt < NTOK) begin
            @(negedge clk);
            if (&(q_t | q_f)) begin
                logic [WIDTH-1:0] exp_w;
                exp_w = (sent_q.size() > 0) ? sent_q.pop_front() : 'x;
                check(q_t === exp_w && q_f === ~exp_w, "R7 word order/value", q_t, exp_w);
                rx_cnt++;
                cyc($urandom_range(0, 4));
                dn_ack = 1'b1;
                while ((q_t | q_f) != '0) @(negedge clk);
                cyc($urandom_range(0, 4));
                dn_ack = 1'b0;
            end
        end
    end

    initial begin : main
        cyc(3);
        check(q_t == '0 && q_f == '0, "R1 reset rails", {q_t, q_f}, 0);
        check(up_ack == 1'b0, "R1 reset ack", up_ack, 0);
        rst_n = 1'b1;
        cyc(1);
        // R4: valid word offered while downstream still acknowledging
        dn_ack = 1'b1; d_t = '1;
        cyc(3);
        check(q_t == '0, "R4 no capture while dn_ack high", q_t, 0);
        check(up_ack == 1'b0, "R4 ack stays low", up_ack, 0);
        // R2: capture once downstream idles
        dn_ack = 1'b0;
        cyc(1);
        check(q_t == '1 && q_f == '0, "R2 capture", q_t, '1);
        check(up_ack == 1'b1, "R6 ack on full word", up_ack, 1);
        // R4: empty input with downstream idle holds the word
        d_t = '0;
        cyc(3);
        check(q_t == '1, "R4 hold while dn_ack low", q_t, '1);
        // R3: downstream takes it
        dn_ack = 1'b1;
        cyc(1);
        check(q_t == '0 && q_f == '0, "R3 clear", q_t, 0);
        check(up_ack == 1'b0, "R6 ack on empty word", up_ack, 0);
        dn_ack = 1'b0;
        cyc(1);
        // R6: partial word keeps ack low
        d_f[0] = 1'b1;
        cyc(2);
        check(q_f == 4'b0001, "R2 single bit captured", q_f, 1);
        check(up_ack == 1'b0, "R6 partial word no ack", up_ack, 0);
        d_f[0] = 1'b0; dn_ack = 1'b1;
        cyc(1);
        check(q_f == '0, "R3 single bit cleared", q_f, 0);
        dn_ack = 1'b0;
        cyc(2);
        // R7: random four-phase traffic
        model_on = 1'b1;
        for (int n = 0; n < NTOK; n++) begin
            send(WIDTH'($urandom));
            cyc($urandom_range(0, 3));
        end
        while (rx_cnt < NTOK) @(negedge clk);
        check(sent_q.size() == 0, "R7 all words delivered", sent_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule